// File: doc/BRIEF.md
# Ownership Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus, using a write-invalidate scheme. Each line is in one of four states. Invalid holds nothing. Shared is a clean copy that does not own the line. Shared-Dirty owns the line while other copies may exist. Dirty is the only copy, and it is modified. The owner of a line, not main memory, holds the current value. The owner answers other caches' read requests directly, and it raises an inhibit signal so that memory stays silent. A dirty owner that serves a read keeps ownership in the Shared-Dirty state. A write to a copy that is already present sends only an address-only invalidate on the bus.

The processor side uses a valid/ready request handshake. Each accepted request ends with a one-cycle completion pulse. The bus side raises a request with a command and a line address and holds it until an external arbiter grants it. Snooped commands arrive on a separate port, one per cycle. A small direct-mapped tag/state array holds the line states. The data array, the arbiter and memory sit outside the block. All addresses are line addresses: the low index bits select the array entry and the upper bits form the tag.

Top module: `own_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No request is pending, no inhibit is asserted, cpuReady is 1, and the first access to any address goes to the bus.
- R2: A read that hits a line in Shared, Shared-Dirty or Dirty completes with a cpuDone pulse, makes no bus request and leaves the state unchanged.
- R3: A read miss issues BusRd (command code 1) for the requested line address, and the line is then filled as Shared.
- R4: A snooped BusRd that hits a Dirty line asserts snpInhibit in the cycle after the snoop and moves the line to Shared-Dirty. On a Shared-Dirty line it asserts snpInhibit and keeps the state. On a Shared line or on a tag mismatch it asserts nothing.
- R5: A write that hits a Dirty line completes locally with no bus request.
- R6: A write that hits a Shared or Shared-Dirty line issues BusInv (code 3) for that line and moves it to Dirty.
- R7: A write miss issues BusRdX (code 2) and fills the line as Dirty.
- R8: A snooped BusRdX (code 2) or BusInv (code 3) moves a Shared line to Invalid without inhibit. An owner (Dirty or Shared-Dirty) that snoops BusRdX asserts snpInhibit and moves to Invalid.
- R9: snpInhibit is asserted only in the cycle after a snooped BusRd or BusRdX. A snooped write-back (code 4) never asserts it.
- R10: A miss that evicts a Dirty or Shared-Dirty line first issues a write-back (code 4) with the victim's line address, then issues the fill request. Evicting a Shared line issues no write-back.
- R11: cpuReady is low from the cycle after a request is accepted until completion. cpuDone is a single-cycle pulse.
- R12: busReq, once raised, stays high until busGnt, and whenever busReq is high busCmd carries one of codes 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | LADDR_W | Processor line address |
| cpuReady | output | 1 | Controller can accept a request |
| cpuDone | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 3 | 1 BusRd, 2 BusRdX, 3 BusInv, 4 write-back |
| busAddr | output | LADDR_W | Line address of the bus transaction |
| busGnt | input | 1 | Grant; the transaction takes place in this cycle |
| snpValid | input | 1 | Snooped command valid |
| snpCmd | input | 3 | Snooped command code |
| snpAddr | input | LADDR_W | Snooped line address |
| snpInhibit | output | 1 | Owner supplies data; memory must not respond |

## Verification
The assertions assume the bus is serialized. A snoop never arrives in the same cycle as this controller's own grant, and busGnt is only raised while busReq is high. The stimulus respects both assumptions. It runs processor operations and snoops strictly one after another, and the bus stub grants only a pending request, a fixed two cycles after it sees it. Line states are never read directly. Each state is inferred from which bus command, if any, the next access produces, and from whether a snooped read draws an inhibit.

// File: rtl/own_snoop_pkg.sv
package own_snoop_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_SHD = 2'd2,
    LN_DRT = 2'd3
  } lineSt_t;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } busCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;    // latch processor address
    logic    cpuWr;      // write state of request line
    lineSt_t cpuSt;
    logic    addrVictim; // drive victim address on bus
    logic    snpWr;      // write state of snooped line
    lineSt_t snpSt;
  } dpCtl_t;

endpackage

// File: rtl/own_snoop_dp.sv
module own_snoop_dp
  import own_snoop_pkg::*;
#(
  parameter int LADDR_W = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtl_t             ctl,
  input  logic [LADDR_W-1:0] cpuAddr,
  input  logic [LADDR_W-1:0] snpAddr,
  output lineSt_t            reqState,
  output logic               victimOwned,
  output lineSt_t            snpState,
  output logic [LADDR_W-1:0] busAddr
);
  localparam int TAG_W = LADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LADDR_W-1:0] reqAddrQ;
  logic [IDX_W-1:0]   reqIdx, snpIdx;
  logic [TAG_W-1:0]   reqTag, snpTag;

  lineSt_t          stateVec [LINES];
  logic [TAG_W-1:0] tagVec   [LINES];

  assign reqIdx = reqAddrQ[IDX_W-1:0];
  assign reqTag = reqAddrQ[LADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[LADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n)           reqAddrQ <= '0;
    else if (ctl.capture) reqAddrQ <= cpuAddr;
  end

  for (genvar g = 0; g < LINES; g++) begin : gLine
    lineSt_t          stQ;
    logic [TAG_W-1:0] tagQ;
    logic             cpuSel, snpSel;

    assign cpuSel = ctl.cpuWr && (reqIdx == IDX_W'(g));
    assign snpSel = ctl.snpWr && (snpIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)      stQ <= LN_INV;
      else if (cpuSel) stQ <= ctl.cpuSt;
      else if (snpSel) stQ <= ctl.snpSt;
    end

    always_ff @(posedge clk) begin
      if (cpuSel && ctl.cpuSt != LN_INV) tagQ <= reqTag;
    end

    assign stateVec[g] = stQ;
    assign tagVec[g]   = tagQ;
  end

  lineSt_t          reqRaw, snpRaw;
  logic [TAG_W-1:0] reqTagRd, snpTagRd;

  always_comb begin
    reqRaw   = stateVec[reqIdx];
    reqTagRd = tagVec[reqIdx];
    snpRaw   = stateVec[snpIdx];
    snpTagRd = tagVec[snpIdx];

    reqState    = (reqRaw != LN_INV && reqTagRd == reqTag) ? reqRaw : LN_INV;
    snpState    = (snpRaw != LN_INV && snpTagRd == snpTag) ? snpRaw : LN_INV;
    victimOwned = (reqRaw == LN_SHD || reqRaw == LN_DRT) && (reqTagRd != reqTag);
    busAddr     = ctl.addrVictim ? {reqTagRd, reqIdx} : reqAddrQ;
  end

endmodule

// File: rtl/own_snoop_ctl.sv
module own_snoop_ctl
  import own_snoop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpuValid,
  input  logic    cpuWrite,
  output logic    cpuReady,
  output logic    cpuDone,
  output logic    busReq,
  output busCmd_t busCmd,
  input  logic    busGnt,
  input  logic    snpValid,
  input  busCmd_t snpCmd,
  output logic    snpInhibit,
  input  lineSt_t reqState,
  input  logic    victimOwned,
  input  lineSt_t snpState,
  output dpCtl_t  ctl
);
  typedef enum logic {CS_IDLE, CS_BUSY} ctlSt_t;

  ctlSt_t stQ;
  logic   writeQ, doneQ, inhibitQ;
  logic   finish, inhibitD;

  always_comb begin
    ctl      = '0;
    busReq   = 1'b0;
    busCmd   = BC_NONE;
    finish   = 1'b0;
    inhibitD = 1'b0;
    cpuReady = (stQ == CS_IDLE);
    ctl.capture = cpuValid && cpuReady;

    // processor side, re-evaluated every cycle against live state
    if (stQ == CS_BUSY) begin
      if (reqState != LN_INV) begin
        if (!writeQ || reqState == LN_DRT) begin
          finish = 1'b1;
        end else begin
          busReq = 1'b1;
          busCmd = BC_INV;
          if (busGnt) begin
            ctl.cpuWr = 1'b1;
            ctl.cpuSt = LN_DRT;
            finish    = 1'b1;
          end
        end
      end else if (victimOwned) begin
        busReq         = 1'b1;
        busCmd         = BC_WB;
        ctl.addrVictim = 1'b1;
        if (busGnt) begin
          ctl.cpuWr = 1'b1;
          ctl.cpuSt = LN_INV;
        end
      end else begin
        busReq = 1'b1;
        busCmd = writeQ ? BC_RDX : BC_RD;
        if (busGnt) begin
          ctl.cpuWr = 1'b1;
          ctl.cpuSt = writeQ ? LN_DRT : LN_SHR;
          finish    = 1'b1;
        end
      end
    end

    // snoop side
    if (snpValid) begin
      unique case (snpCmd)
        BC_RD: begin
          if (snpState == LN_DRT) begin
            ctl.snpWr = 1'b1;
            ctl.snpSt = LN_SHD;
            inhibitD  = 1'b1;
          end else if (snpState == LN_SHD) begin
            inhibitD = 1'b1;
          end
        end
        BC_RDX: begin
          if (snpState != LN_INV) begin
            ctl.snpWr = 1'b1;
            ctl.snpSt = LN_INV;
            inhibitD  = (snpState == LN_SHD) || (snpState == LN_DRT);
          end
        end
        BC_INV: begin
          if (snpState != LN_INV) begin
            ctl.snpWr = 1'b1;
            ctl.snpSt = LN_INV;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stQ      <= CS_IDLE;
      writeQ   <= 1'b0;
      doneQ    <= 1'b0;
      inhibitQ <= 1'b0;
    end else begin
      doneQ    <= finish;
      inhibitQ <= inhibitD;
      if (ctl.capture) begin
        stQ    <= CS_BUSY;
        writeQ <= cpuWrite;
      end else if (finish) begin
        stQ <= CS_IDLE;
      end
    end
  end

  assign cpuDone    = doneQ;
  assign snpInhibit = inhibitQ;

endmodule

// File: rtl/own_snoop_ctrl.sv
module own_snoop_ctrl
  import own_snoop_pkg::*;
#(
  parameter int LADDR_W = 12,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpuValid,
  input  logic               cpuWrite,
  input  logic [LADDR_W-1:0] cpuAddr,
  output logic               cpuReady,
  output logic               cpuDone,
  output logic               busReq,
  output logic [2:0]         busCmd,
  output logic [LADDR_W-1:0] busAddr,
  input  logic               busGnt,
  input  logic               snpValid,
  input  logic [2:0]         snpCmd,
  input  logic [LADDR_W-1:0] snpAddr,
  output logic               snpInhibit
);
  dpCtl_t  ctl;
  lineSt_t reqState, snpState;
  logic    victimOwned;
  busCmd_t busCmdInt;

  own_snoop_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpuValid   (cpuValid),
    .cpuWrite   (cpuWrite),
    .cpuReady   (cpuReady),
    .cpuDone    (cpuDone),
    .busReq     (busReq),
    .busCmd     (busCmdInt),
    .busGnt     (busGnt),
    .snpValid   (snpValid),
    .snpCmd     (busCmd_t'(snpCmd)),
    .snpInhibit (snpInhibit),
    .reqState   (reqState),
    .victimOwned(victimOwned),
    .snpState   (snpState),
    .ctl        (ctl)
  );

  own_snoop_dp #(.LADDR_W(LADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .cpuAddr    (cpuAddr),
    .snpAddr    (snpAddr),
    .reqState   (reqState),
    .victimOwned(victimOwned),
    .snpState   (snpState),
    .busAddr    (busAddr)
  );

  assign busCmd = busCmdInt;

endmodule

// File: rtl/own_snoop_chk.sv
module own_snoop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpuValid,
  input logic       cpuReady,
  input logic       cpuDone,
  input logic       busReq,
  input logic [2:0] busCmd,
  input logic       busGnt,
  input logic       snpValid,
  input logic [2:0] snpCmd,
  input logic       snpInhibit
);

  p_inhibit_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snpInhibit |-> $past(snpValid) && ($past(snpCmd) == 3'd1 || $past(snpCmd) == 3'd2));

  p_wb_snoop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snpValid && snpCmd == 3'd4) |=> !snpInhibit);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busGnt) |=> busReq);

  p_cmd_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |-> (busCmd >= 3'd1 && busCmd <= 3'd4));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpuDone |=> !cpuDone);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuValid && cpuReady) |=> !cpuReady);

  p_done_returns_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpuDone |-> cpuReady);

endmodule

bind own_snoop_ctrl own_snoop_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpuValid  (cpuValid),
  .cpuReady  (cpuReady),
  .cpuDone   (cpuDone),
  .busReq    (busReq),
  .busCmd    (busCmd),
  .busGnt    (busGnt),
  .snpValid  (snpValid),
  .snpCmd    (snpCmd),
  .snpInhibit(snpInhibit)
);

// File: tb/test_own_snoop_ctrl.sv
`timescale 1ns/1ps
module test_own_snoop_ctrl;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [LW-1:0] cpuAddr = '0;
  logic          cpuReady, cpuDone, busReq, snpInhibit;
  logic [2:0]    busCmd;
  logic [LW-1:0] busAddr;
  logic          busGnt = 1'b0;
  logic          snpValid = 1'b0;
  logic [2:0]    snpCmd = '0;
  logic [LW-1:0] snpAddr = '0;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  logic [14:0] expQ[$];

  always #2.5 clk = ~clk;

  own_snoop_ctrl #(.LADDR_W(LW), .IDX_W(4)) i_own_snoop_ctrl (.*);

  function automatic logic [LW-1:0] la(input int tag, input int idx);
    return {tag[7:0], idx[3:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_bus(input logic [2:0] cmd, input logic [LW-1:0] a);
    expQ.push_back({cmd, a});
  endtask

  // bus stub / monitor: grants two cycles after seeing a request, compares
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (busGnt) begin
        busGnt = 1'b0;
      end else if (busReq) begin
        waitCnt++;
        if (waitCnt == 2) begin
          waitCnt = 0;
          if (expQ.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL %s unexpected bus request actual=%0h expected=none", curReq, {busCmd, busAddr});
          end else begin
            chk({curReq, " bus transaction"}, 32'({busCmd, busAddr}), 32'(expQ.pop_front()));
          end
          busGnt = 1'b1;
        end
      end
    end
  end

  task automatic cpuOp(input logic w, input logic [LW-1:0] a, input string req);
    int n = 0;
    curReq = req;
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = w; cpuAddr = a;
    @(negedge clk);
    cpuValid = 1'b0;
    chk({req, " R11 ready low while busy"}, 32'(cpuReady), 0);
    while (!cpuDone && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk({req, " completion pulse"}, 32'(cpuDone), 1);
    chk({req, " expected bus traffic consumed"}, 32'(expQ.size()), 0);
    expQ.delete();
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [LW-1:0] a, input logic expInh, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a;
    @(negedge clk);
    snpValid = 1'b0;
    chk({req, " inhibit"}, 32'(snpInhibit), 32'(expInh));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LW-1:0] A, B, C, X, E, F;
    A = la(1, 2); B = la(3, 2); C = la(4, 2); X = la(2, 2); E = la(5, 7); F = la(0, 9);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 32'(cpuReady), 1);
    chk("R1 reset busReq", 32'(busReq), 0);
    chk("R1 reset done", 32'(cpuDone), 0);
    chk("R1 reset inhibit", 32'(snpInhibit), 0);

    expect_bus(3'd1, F); cpuOp(1'b0, F, "R1 fresh line misses");

    expect_bus(3'd1, A); cpuOp(1'b0, A, "R3 read miss");
    cpuOp(1'b0, A, "R2 read hit S");
    snoop(3'd1, A, 1'b0, "R4 snoop rd on S");
    expect_bus(3'd3, A); cpuOp(1'b1, A, "R6 write hit S");
    cpuOp(1'b1, A, "R5 write hit D");
    snoop(3'd1, A, 1'b1, "R4 snoop rd on D");
    cpuOp(1'b0, A, "R2 read hit SD");
    snoop(3'd1, A, 1'b1, "R4 snoop rd on SD");
    expect_bus(3'd3, A); cpuOp(1'b1, A, "R6 write hit SD");
    snoop(3'd2, A, 1'b1, "R8 snoop rdx on D");
    expect_bus(3'd1, A); cpuOp(1'b0, A, "R8 line invalid after rdx");
    snoop(3'd3, A, 1'b0, "R8 snoop inv on S");
    expect_bus(3'd1, A); cpuOp(1'b0, A, "R8 line invalid after inv");
    snoop(3'd2, A, 1'b0, "R8 snoop rdx on S");
    expect_bus(3'd2, A); cpuOp(1'b1, A, "R7 write miss");
    cpuOp(1'b1, A, "R7 filled as D");
    snoop(3'd1, X, 1'b0, "R4 tag mismatch");
    snoop(3'd1, A, 1'b1, "R4 still owner after mismatch");
    expect_bus(3'd3, A); cpuOp(1'b1, A, "R6 write hit SD again");

    expect_bus(3'd4, A); expect_bus(3'd2, B); cpuOp(1'b1, B, "R10 evict D on write miss");
    expect_bus(3'd4, B); expect_bus(3'd1, A); cpuOp(1'b0, A, "R10 evict D on read miss");
    expect_bus(3'd1, C); cpuOp(1'b0, C, "R10 silent evict S");
    snoop(3'd4, C, 1'b0, "R9 snooped write-back");
    snoop(3'd1, C, 1'b0, "R4 snoop rd on S after fill");
    expect_bus(3'd3, C); cpuOp(1'b1, C, "R6 write hit S after fill");

    expect_bus(3'd1, E); cpuOp(1'b0, E, "R3 read miss other index");
    snoop(3'd2, E, 1'b0, "R8 snoop rdx on S other index");
    expect_bus(3'd1, E); cpuOp(1'b0, E, "R3 refill after invalidate");
    chk("R12 bus idle at end", 32'(busReq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule